// File: doc/BRIEF.md
# Bidirectional Open-Drain Bus Repeater

This block joins two open-drain serial bus segments, side A and side B, through two identical channels. Channel 0 carries the clock line and channel 1 carries the data line. Each side of each channel has a sampled line input and an active-high pull-down request output. An external open-drain pad pulls the line low while that request is set. When a device on one side pulls a line low, the block pulls the same line low on the other side. Clock stretching and arbitration therefore reach both segments.

Each channel records which side pulled low first, so a low that the block drives itself is never read back as an outside low. After the side that started a low lets go, the channel releases its own pull-down. It then waits out the synchronizer delay before it accepts a new low. A low that an outside device still holds on the formerly driven side is then passed back the other way, as a stretch.

The pull-downs stay released until both supply-good flags are set. The enable input is active high. A change on it takes effect only while the bus is idle. Idle means both lines are high and either a STOP was the last bus event or the lines have stayed high for a set number of cycles.

Top module: `od_bus_repeater`

## Requirements
- R1: While reset is held and just after it, every pull-down output is 0, every channel state is 0 and `en_active` is 0.
- R2: When side A of a channel goes low from the idle state, the block sets that channel's B pull-down. It clears it once A is high again.
- R3: When side B of a channel goes low while A is high, the block sets that channel's A pull-down. It clears it once B is released.
- R4: After the side that started a low releases it, both pull-downs of that channel clear and the state returns to 0 (idle). The low that the block drove is not taken as an outside low, so the channel does not lock up.
- R5: If an outside device still holds the driven side low when the starting side releases, the channel reverses and pulls the starting side low (state 2). This passes a stretch back across.
- R6: The two channels work independently of each other.
- R7: No pull-down is set unless both `supply_a_ok` and `supply_b_ok` are 1. The two flags may rise in either order.
- R8: While `en_active` is 0, no pull-down is set and the channel states stay 0.
- R9: A change on `rpt_en` reaches `en_active` only while the bus is idle. After a START (data falls while clock is high), `en_active` holds its value until a STOP (data rises while clock is high).
- R10: Without a STOP, the bus also counts as idle once both lines have been high for `IDLE_CYCLES` consecutive cycles.
- R11: `chan_state` holds two bits per channel, with channel 0 in bits 1:0. The codes are 0 idle, 1 A started the low, 2 B started the low and 3 settling after release.
- R12: When both sides of a channel go low in the same sample, side A takes priority and the channel enters state 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rpt_en | input | 1 | Requested enable, active high |
| supply_a_ok | input | 1 | Side A supply good |
| supply_b_ok | input | 1 | Side B supply good |
| a_in | input | 2 | Sampled side A lines (bit 0 clock, bit 1 data) |
| b_in | input | 2 | Sampled side B lines (bit 0 clock, bit 1 data) |
| a_pd | output | 2 | Side A pull-down requests |
| b_pd | output | 2 | Side B pull-down requests |
| chan_state | output | 4 | Per-channel direction state |
| en_active | output | 1 | Enable currently in effect |

## Verification
Two situations are hard to reach from the ports. The first is the stretch hand-back of R5, where an outside device still holds the driven side low when the starting side lets go. The bench reaches it by holding both sides low together and then releasing only side A. The second is the counted-idle path of R10. It needs a START followed by the data line rising while the clock is low, which is never a STOP. The bench builds that sequence by hand on side A and withdraws the enable halfway through, so that only the idle counter can apply the change.

// File: rtl/rptr_pkg.sv
package rptr_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_SCL = 0;
  localparam int CH_SDA = 1;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_A_DRV  = 2'd1,
    ST_B_DRV  = 2'd2,
    ST_SETTLE = 2'd3
  } ch_state_e;

  function automatic logic lines_high(input logic scl, input logic sda);
    return scl & sda;
  endfunction

  function automatic logic is_start(input logic scl_p, input logic sda_p,
                                    input logic scl, input logic sda);
    return scl_p & scl & sda_p & ~sda;
  endfunction

  function automatic logic is_stop(input logic scl_p, input logic sda_p,
                                   input logic scl, input logic sda);
    return scl_p & scl & ~sda_p & sda;
  endfunction
endpackage

// File: rtl/rptr_sync.sv
module rptr_sync #(
  parameter int       W       = 1,
  parameter int       STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rptr_channel.sv
module rptr_channel
  import rptr_pkg::*;
#(
  parameter int SETTLE_CYCLES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go,
  input  logic      a_s,
  input  logic      b_s,
  output logic      a_pd,
  output logic      b_pd,
  output ch_state_e state
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);

  ch_state_e      state_q, state_d;
  logic [CW-1:0]  cnt_q;

  // named events for the checks
  logic a_ext_low, b_ext_low, settle_done;
  assign a_ext_low   = ~a_s;
  assign b_ext_low   = ~b_s;
  assign settle_done = (cnt_q == CW'(1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (go && a_ext_low)      state_d = ST_A_DRV;
                 else if (go && b_ext_low) state_d = ST_B_DRV;
      ST_A_DRV:  if (!go || a_s)           state_d = ST_SETTLE;
      ST_B_DRV:  if (!go || b_s)           state_d = ST_SETTLE;
      ST_SETTLE: if (settle_done)          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d == ST_SETTLE && state_q != ST_SETTLE) cnt_q <= CW'(SETTLE_CYCLES);
      else if (cnt_q != '0)                             cnt_q <= cnt_q - CW'(1);
    end
  end

  assign a_pd  = (state_q == ST_B_DRV);
  assign b_pd  = (state_q == ST_A_DRV);
  assign state = state_q;

  // R2
  a_low_copies_to_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && go && a_ext_low) |=> b_pd);
  // R3
  b_low_copies_to_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && go && a_s && b_ext_low) |=> a_pd);
  // R4
  own_low_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_B_DRV && b_s) |=> (!a_pd && !b_pd));
  // R7
  no_drive_without_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!go) |=> (!a_pd && !b_pd));
endmodule

// File: rtl/rptr_idle_gate.sv
module rptr_idle_gate
  import rptr_pkg::*;
#(
  parameter int IDLE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  input  logic en_req,
  output logic en_eff
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);

  logic          scl_q, sda_q, busy_q, en_q;
  logic [CW-1:0] hi_cnt_q;

  logic start_evt, stop_evt, both_hi, cnt_full, bus_idle;
  assign both_hi   = lines_high(scl, sda);
  assign start_evt = is_start(scl_q, sda_q, scl, sda);
  assign stop_evt  = is_stop(scl_q, sda_q, scl, sda);
  assign cnt_full  = (hi_cnt_q == CW'(IDLE_CYCLES));
  assign bus_idle  = both_hi && (!busy_q || cnt_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      busy_q   <= 1'b0;
      hi_cnt_q <= '0;
      en_q     <= 1'b0;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      if (start_evt)                 busy_q <= 1'b1;
      else if (stop_evt || cnt_full) busy_q <= 1'b0;
      if (!both_hi)       hi_cnt_q <= '0;
      else if (!cnt_full) hi_cnt_q <= hi_cnt_q + CW'(1);
      if (bus_idle) en_q <= en_req;
    end
  end

  assign en_eff = en_q;

  // R9
  en_held_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_idle) |=> $stable(en_q));
  // R9
  start_marks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy_q);
  // R10
  idle_count_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_full && both_hi) |=> (en_q == $past(en_req)));
endmodule

// File: rtl/od_bus_repeater.sv
module od_bus_repeater
  import rptr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_CYCLES = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rpt_en,
  input  logic                  supply_a_ok,
  input  logic                  supply_b_ok,
  input  logic [NUM_CH-1:0]     a_in,
  input  logic [NUM_CH-1:0]     b_in,
  output logic [NUM_CH-1:0]     a_pd,
  output logic [NUM_CH-1:0]     b_pd,
  output logic [2*NUM_CH-1:0]   chan_state,
  output logic                  en_active
);
  localparam int BUS_W = 2 * NUM_CH;

  logic [BUS_W-1:0]  bus_s;
  logic [NUM_CH-1:0] a_s, b_s, line_s;
  logic [2:0]        ctl_s;
  logic              pwr_ok, en_eff, go;

  rptr_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL({BUS_W{1'b1}})) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({b_in, a_in}), .q(bus_s));

  rptr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({rpt_en, supply_b_ok, supply_a_ok}), .q(ctl_s));

  assign a_s    = bus_s[NUM_CH-1:0];
  assign b_s    = bus_s[BUS_W-1:NUM_CH];
  assign line_s = a_s & b_s;
  assign pwr_ok = ctl_s[0] & ctl_s[1];

  rptr_idle_gate #(.IDLE_CYCLES(IDLE_CYCLES)) u_gate (
    .clk(clk), .rst_n(rst_n), .scl(line_s[CH_SCL]), .sda(line_s[CH_SDA]),
    .en_req(ctl_s[2]), .en_eff(en_eff));

  assign go        = en_eff & pwr_ok;
  assign en_active = en_eff;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    ch_state_e st;
    rptr_channel #(.SETTLE_CYCLES(SYNC_STAGES)) u_ch (
      .clk(clk), .rst_n(rst_n), .go(go), .a_s(a_s[i]), .b_s(b_s[i]),
      .a_pd(a_pd[i]), .b_pd(b_pd[i]), .state(st));
    assign chan_state[2*i +: 2] = st;
  end

  // R7
  no_pd_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_ok) |=> ((a_pd | b_pd) == '0));
endmodule

// File: tb/test_od_bus_repeater.sv
module test_od_bus_repeater;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rpt_en = 1'b0, supply_a_ok = 1'b0, supply_b_ok = 1'b0;
  logic [1:0] ext_a = 2'b00, ext_b = 2'b00;
  logic [1:0] a_in, b_in, a_pd, b_pd;
  logic [3:0] chan_state;
  logic       en_active;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  localparam int IDLE_N = 32;

  always #2.5 clk = ~clk;

  // wired-AND buses with pull-ups
  assign a_in = ~(a_pd | ext_a);
  assign b_in = ~(b_pd | ext_b);

  od_bus_repeater #(.SYNC_STAGES(2), .IDLE_CYCLES(IDLE_N)) i_od_bus_repeater (
    .clk(clk), .rst_n(rst_n), .rpt_en(rpt_en), .supply_a_ok(supply_a_ok),
    .supply_b_ok(supply_b_ok), .a_in(a_in), .b_in(b_in), .a_pd(a_pd),
    .b_pd(b_pd), .chan_state(chan_state), .en_active(en_active));

  // {ext_a, ext_b, exp a_pd, exp b_pd, exp chan_state}
  localparam logic [11:0] VEC [10] = '{
    12'b00_00_00_00_0000,
    12'b01_00_00_01_0001,
    12'b00_00_00_00_0000,
    12'b00_10_10_00_1000,
    12'b00_00_00_00_0000,
    12'b01_10_10_01_1001,
    12'b00_00_00_00_0000,
    12'b01_01_00_01_0001,
    12'b00_01_01_00_0010,
    12'b00_00_00_00_0000
  };

  function automatic string vec_tag(input int idx);
    case (idx)
      1: return "R2";
      3: return "R3";
      5: return "R6";
      7: return "R12";
      8: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_idle_outputs(input string req);
    chk(req, {28'd0, a_pd, b_pd}, 32'd0);
    chk(req, {28'd0, chan_state}, 32'd0);
  endtask

  initial begin
    cyc(3);
    // R1: reset state
    chk_idle_outputs("R1");
    chk("R1", {31'd0, en_active}, 32'd0);
    rst_n = 1'b1;
    cyc(1);
    chk_idle_outputs("R1");
    supply_a_ok = 1'b1; supply_b_ok = 1'b1; rpt_en = 1'b1;
    cyc(10);
    chk("R9 enable adopted while idle", {31'd0, en_active}, 32'd1);

    // table walk: R2 R3 R4 R5 R6 R11 R12
    for (int v = 0; v < 10; v++) begin
      ext_a = VEC[v][11:10];
      ext_b = VEC[v][9:8];
      cyc(14);
      chk(vec_tag(v), {30'd0, a_pd}, {30'd0, VEC[v][7:6]});
      chk(vec_tag(v), {30'd0, b_pd}, {30'd0, VEC[v][5:4]});
      chk({vec_tag(v), " R11"}, {28'd0, chan_state}, {28'd0, VEC[v][3:0]});
    end

    // R7: supplies in either order
    supply_b_ok = 1'b0;
    cyc(6);
    ext_a = 2'b01;
    cyc(10);
    chk("R7 b supply low", {30'd0, b_pd}, 32'd0);
    supply_b_ok = 1'b1; supply_a_ok = 1'b0;
    cyc(10);
    chk("R7 a supply low", {30'd0, b_pd}, 32'd0);
    supply_a_ok = 1'b1;
    cyc(10);
    chk("R7 both good", {30'd0, b_pd}, 32'd1);
    ext_a = 2'b00;
    cyc(14);
    chk_idle_outputs("R4");

    // R9: enable withdrawn inside a transfer
    ext_a = 2'b10;              // START
    cyc(10);
    rpt_en = 1'b0;
    cyc(20);
    chk("R9 held during transfer", {31'd0, en_active}, 32'd1);
    chk("R9 still repeating", {30'd0, b_pd}, 32'd2);
    ext_a = 2'b00;              // STOP
    cyc(14);
    chk("R9 applied after stop", {31'd0, en_active}, 32'd0);

    // R8: disabled, lows are not copied
    ext_a = 2'b01;
    cyc(12);
    chk_idle_outputs("R8");
    ext_a = 2'b00;
    ext_b = 2'b01;
    cyc(12);
    chk_idle_outputs("R8");
    ext_b = 2'b00;
    cyc(6);
    rpt_en = 1'b1;
    cyc(10);
    chk("R9 re-enable when idle", {31'd0, en_active}, 32'd1);

    // R10: no STOP, counted idle
    ext_a = 2'b10;              // START
    cyc(10);
    ext_a = 2'b11;              // clock low
    cyc(10);
    ext_a = 2'b01;              // data rises while clock low
    cyc(10);
    rpt_en = 1'b0;
    cyc(4);
    ext_a = 2'b00;              // both high, still busy
    cyc(12);
    chk("R10 before count", {31'd0, en_active}, 32'd1);
    cyc(IDLE_N + 10);
    chk("R10 after count", {31'd0, en_active}, 32'd0);
    chk_idle_outputs("R10");

    done = 1'b1;
  end

  initial begin
    int t = 0;
    while (!done && t < 200000) begin
      @(posedge clk);
      t++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", t);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule